// File: doc/BRIEF.md
# Serial Debug Monitor Command Sequencer

This block sits behind a byte-level serial line interface and carries out memory-debug commands sent by a host. The host sends an opcode byte and any operand bytes. The block echoes every byte back so the host can detect errors. It then returns any read data and holds a quiet window at the end of the command. The command's effect (a memory write, a pointer update or a run request) takes place only after that window closes. A break reported by the line interface at any moment drops the command in progress.

The commands are: read a byte at an absolute address, write a byte at an absolute address, read two bytes through an internal pointer, write one byte through the pointer, read the 16-bit stack pointer, and request that the user program start. All delays are counted in bit times of `BIT_CYCLES` clock cycles each. The memory port is synchronous: read data is valid in the cycle after the request.

Top module: `dbg_cmd_seq`

## Requirements
- R1: Opcodes are 0x4A read, 0x49 write, 0x1A indexed read, 0x19 indexed write, 0x0C read stack pointer and 0x28 run. Any other opcode is echoed and then has no further effect: no data, no window, no write and no run request.
- R2: Each accepted byte is echoed with `tx_valid_o` high for one cycle, exactly 2*BIT_CYCLES cycles after the cycle in which `rx_valid_i` presented it, with `tx_data_o` equal to that byte.
- R3: Read (0x4A, address high byte then low byte) returns the memory byte at that address. The byte is sent 2*BIT_CYCLES cycles after the final echo, and the internal pointer is set to the address at commit.
- R4: Write (0x49, address high, address low, data) performs one memory write of the data at the address at commit, and sets the pointer to the address.
- R5: Indexed read (0x1A) returns the bytes at pointer and pointer+1. Each byte is sent 2*BIT_CYCLES cycles after the previous transmission, and the pointer advances by 2 at commit.
- R6: Indexed write (0x19, data) writes the data at the pointer at commit, and the pointer advances by 1.
- R7: Read stack pointer (0x0C) returns `sp_i` high byte first, then low byte, with the same spacing as R5.
- R8: Run (0x28) raises `run_o` for exactly one cycle, at commit.
- R9: Commit happens exactly 11*BIT_CYCLES cycles after the last transmission of a recognised command. No memory write, run request or transmission occurs inside that window.
- R10: `rx_break_i` in any state returns the block to waiting for an opcode, with no echo pending, no memory write, no run request and the pointer unchanged.
- R11: A byte presented on `rx_valid_i` while an echo, a data byte or the window is pending is ignored.
- R12: After reset no transmission, memory request or run request is active, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte strobe from line interface |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Break detected by line interface |
| tx_valid_o | output | 1 | Transmit byte strobe |
| tx_data_o | output | 8 | Byte to transmit |
| sp_i | input | 16 | Current stack pointer value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write enable, qualifies mem_req_o |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid one cycle after a read request |
| run_o | output | 1 | One-cycle request to start the user program |

## Verification
The echo is due 2*BIT_CYCLES cycles after the cycle that presents the byte. Each returned data byte is due 2*BIT_CYCLES cycles after the preceding transmission, and the commit (write, run or nothing) is due 11*BIT_CYCLES cycles after the last transmission. The bench counts falling edges from each stimulus to the exact due cycle. At every edge before that cycle it checks that no strobe is active, and at the due cycle it checks the strobe and its data. Cancelled and ignored stimuli are judged by the absence of strobes over a full window, and by the pointer value seen through a later indexed read.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;
  localparam logic [7:0] OP_RD  = 8'h4A;
  localparam logic [7:0] OP_WR  = 8'h49;
  localparam logic [7:0] OP_IRD = 8'h1A;
  localparam logic [7:0] OP_IWR = 8'h19;
  localparam logic [7:0] OP_RSP = 8'h0C;
  localparam logic [7:0] OP_RUN = 8'h28;

  typedef enum logic [1:0] {S_RX, S_ECHO, S_DATA, S_WIN} seq_state_e;
  typedef enum logic [2:0] {K_NONE, K_RD, K_WR, K_IRD, K_IWR, K_RSP, K_RUN} op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [1:0] last_idx;  // index of final command byte
    logic [1:0] nread;     // bytes returned
    logic       win;       // has end-of-command window
  } op_info_t;
endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
  import dbg_seq_pkg::*;
(
  input  logic [7:0] opcode_i,
  output op_info_t   info_o
);
  always_comb begin
    info_o = '{kind: K_NONE, last_idx: 2'd0, nread: 2'd0, win: 1'b0};
    case (opcode_i)
      OP_RD:  info_o = '{kind: K_RD,  last_idx: 2'd2, nread: 2'd1, win: 1'b1};
      OP_WR:  info_o = '{kind: K_WR,  last_idx: 2'd3, nread: 2'd0, win: 1'b1};
      OP_IRD: info_o = '{kind: K_IRD, last_idx: 2'd0, nread: 2'd2, win: 1'b1};
      OP_IWR: info_o = '{kind: K_IWR, last_idx: 2'd1, nread: 2'd0, win: 1'b1};
      OP_RSP: info_o = '{kind: K_RSP, last_idx: 2'd0, nread: 2'd2, win: 1'b1};
      OP_RUN: info_o = '{kind: K_RUN, last_idx: 2'd0, nread: 2'd0, win: 1'b1};
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_tick_timer.sv
module dbg_tick_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R9
  tmr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(val_i));
endmodule

// File: rtl/dbg_ptr_reg.sv
module dbg_ptr_reg #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] val_i,
  input  logic          inc_i,
  input  logic [1:0]    step_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= val_i;
    else if (inc_i)  ptr_o <= ptr_o + {{(AW-2){1'b0}}, step_i};
  end

  // R10
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !inc_i |=> $stable(ptr_o));
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_seq_pkg::*;
#(
  parameter int BIT_CYCLES = 8,
  parameter int AW         = 16,
  parameter int DW         = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_break_i,
  output logic          tx_valid_o,
  output logic [DW-1:0] tx_data_o,
  input  logic [AW-1:0] sp_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          run_o
);
  localparam int ECHO_DLY = 2 * BIT_CYCLES;
  localparam int WIN_DLY  = 11 * BIT_CYCLES;
  localparam int TW       = $clog2(WIN_DLY + 1);
  localparam logic [TW-1:0] ECHO_LD = TW'(ECHO_DLY - 1);
  localparam logic [TW-1:0] WIN_LD  = TW'(WIN_DLY - 1);

  seq_state_e    state_q;
  logic [1:0]    idx_q, rd_idx_q;
  logic [DW-1:0] opcode_q, byte_q, wdata_q, data_q;
  logic [AW-1:0] addr_q, ptr;
  logic          rd_go_q, cap_q;

  op_info_t      info;
  logic          tmr_load, tmr_done;
  logic [TW-1:0] tmr_val;
  logic          rx_take, echo_fire, data_fire, commit, last_byte, more_rd;
  logic [AW-1:0] rd_addr;
  logic          ptr_load, ptr_inc;
  logic [1:0]    ptr_step;

  dbg_op_decode u_dec (.opcode_i(opcode_q), .info_o(info));

  dbg_tick_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  dbg_ptr_reg #(.AW(AW)) u_ptr (
    .clk_i, .rst_ni, .load_i(ptr_load), .val_i(addr_q),
    .inc_i(ptr_inc), .step_i(ptr_step), .ptr_o(ptr)
  );

  assign rx_take   = (state_q == S_RX) && rx_valid_i && !rx_break_i;
  assign echo_fire = (state_q == S_ECHO) && tmr_done && !rx_break_i;
  assign data_fire = (state_q == S_DATA) && tmr_done && !rx_break_i;
  assign commit    = (state_q == S_WIN) && tmr_done && !rx_break_i;
  assign last_byte = (idx_q == info.last_idx);
  assign more_rd   = ({1'b0, rd_idx_q} + 3'd1) < {1'b0, info.nread};
  assign rd_addr   = (info.kind == K_RD) ? addr_q : ptr + {{(AW-2){1'b0}}, rd_idx_q};

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = ECHO_LD;
    if (rx_take) begin
      tmr_load = 1'b1;
    end else if (echo_fire && last_byte) begin
      if (info.nread != 2'd0) begin
        tmr_load = 1'b1;
      end else if (info.win) begin
        tmr_load = 1'b1;
        tmr_val  = WIN_LD;
      end
    end else if (data_fire) begin
      tmr_load = 1'b1;
      if (!more_rd) tmr_val = WIN_LD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_RX;
      idx_q    <= '0;
      rd_idx_q <= '0;
      opcode_q <= '0;
      byte_q   <= '0;
      wdata_q  <= '0;
      data_q   <= '0;
      addr_q   <= '0;
      rd_go_q  <= 1'b0;
      cap_q    <= 1'b0;
    end else if (rx_break_i) begin
      state_q <= S_RX;
      idx_q   <= '0;
      rd_go_q <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      case (state_q)
        S_RX: if (rx_valid_i) begin
          byte_q  <= rx_data_i;
          state_q <= S_ECHO;
          case (idx_q)
            2'd0: opcode_q <= rx_data_i;
            2'd1: if (info.kind == K_IWR) wdata_q <= rx_data_i;
                  else addr_q[AW-1:AW-8] <= rx_data_i;
            2'd2: addr_q[7:0] <= rx_data_i;
            default: wdata_q <= rx_data_i;
          endcase
        end
        S_ECHO: if (tmr_done) begin
          if (!last_byte) begin
            idx_q   <= idx_q + 2'd1;
            state_q <= S_RX;
          end else begin
            idx_q <= '0;
            if (info.nread != 2'd0) begin
              state_q  <= S_DATA;
              rd_idx_q <= '0;
              rd_go_q  <= 1'b1;
            end else if (info.win) begin
              state_q <= S_WIN;
            end else begin
              state_q <= S_RX;
            end
          end
        end
        S_DATA: begin
          rd_go_q <= 1'b0;
          cap_q   <= rd_go_q && (info.kind != K_RSP);
          if (cap_q) data_q <= mem_rdata_i;
          if (tmr_done) begin
            if (more_rd) begin
              rd_idx_q <= rd_idx_q + 2'd1;
              rd_go_q  <= 1'b1;
            end else begin
              state_q <= S_WIN;
            end
          end
        end
        default: if (tmr_done) state_q <= S_RX;
      endcase
    end
  end

  assign ptr_load = commit && (info.kind == K_RD || info.kind == K_WR);
  assign ptr_inc  = commit && (info.kind == K_IRD || info.kind == K_IWR);
  assign ptr_step = (info.kind == K_IRD) ? 2'd2 : 2'd1;

  assign tx_valid_o = echo_fire || data_fire;
  always_comb begin
    if (state_q == S_ECHO)     tx_data_o = byte_q;
    else if (info.kind == K_RSP) tx_data_o = (rd_idx_q == 2'd0) ? sp_i[AW-1:AW-8] : sp_i[7:0];
    else                       tx_data_o = data_q;
  end

  assign mem_we_o    = commit && (info.kind == K_WR || info.kind == K_IWR);
  assign mem_req_o   = mem_we_o ||
                       ((state_q == S_DATA) && rd_go_q && (info.kind != K_RSP) && !rx_break_i);
  assign mem_addr_o  = (state_q == S_WIN) ? ((info.kind == K_WR) ? addr_q : ptr) : rd_addr;
  assign mem_wdata_o = wdata_q;
  assign run_o       = commit && (info.kind == K_RUN);

  // R2
  echo_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_take |=> !tx_valid_o);
  // R10
  brk_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_break_i |-> !(mem_req_o && mem_we_o) && !run_o && !tx_valid_o);
  // R10
  brk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_break_i |=> (state_q == S_RX) && (idx_q == 2'd0));
  // R8
  run_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> !run_o);
  // R9
  commit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_valid_o, run_o, mem_we_o}));
  // R11
  rx_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_RX) && rx_valid_i && !rx_break_i |=> $stable(byte_q));
endmodule

// File: tb/dbg_cmd_seq_bench.sv
module dbg_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 4;
  localparam int D2   = 2 * BITC;
  localparam int D11  = 11 * BITC;
  localparam int WDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_valid, mem_req, mem_we, run;
  logic [7:0] tx_data, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;
  logic [15:0] sp = 16'hBEEF;
  logic [7:0] mem [256];
  int checks = 0, errors = 0, wr_cnt = 0, run_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_seq #(.BIT_CYCLES(BITC)) u_dbg_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_break_i(rx_break), .tx_valid_o(tx_valid), .tx_data_o(tx_data), .sp_i(sp),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .run_o(run)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
      mem_rdata <= '0;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we) wr_cnt <= wr_cnt + 1;
    if (rst_n && run) run_cnt <= run_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic pulse_break();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic wait_tx(input logic [7:0] exp, input int dly, input string req);
    for (int k = 1; k <= dly; k++) begin
      @(negedge clk);
      if (k < dly && tx_valid) chk(1'b0, req, "early tx", int'(tx_data), int'(exp));
    end
    chk(tx_valid && tx_data == exp, req, "tx byte", tx_valid ? int'(tx_data) : -1, int'(exp));
  endtask

  // ck: 0 nothing, 1 write, 2 run
  task automatic wait_commit(input logic [1:0] ck, input logic [15:0] wa, input logic [7:0] wd);
    for (int k = 1; k <= D11; k++) begin
      @(negedge clk);
      if (k < D11 && (tx_valid || run || (mem_req && mem_we)))
        chk(1'b0, "R9", "activity in window", k, 0);
    end
    case (ck)
      2'd1: chk(mem_req && mem_we && mem_addr == wa && mem_wdata == wd, "R4", "commit write",
                int'({mem_we, mem_addr, mem_wdata}), int'({1'b1, wa, wd}));
      2'd2: chk(run && !(mem_req && mem_we), "R8", "commit run", int'(run), 1);
      default: chk(!run && !(mem_req && mem_we), "R9", "commit none", int'({run, mem_we}), 0);
    endcase
  endtask

  task automatic quiet(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tx_valid || run || (mem_req && mem_we))
        chk(1'b0, req, "unexpected strobe", int'({tx_valid, run, mem_we}), 0);
    end
  endtask

  typedef struct packed {
    logic [2:0]  n;
    logic [7:0]  b0, b1, b2, b3;
    logic [1:0]  nd;
    logic [7:0]  d0, d1;
    logic        win;
    logic [1:0]  ck;
    logic [15:0] wa;
    logic [7:0]  wd;
  } vec_t;

  // mem[a] initial = a[7:0] ^ A5, sp = BEEF
  localparam vec_t VEC [10] = '{
    '{3'd1, 8'h1A, 8'h00, 8'h00, 8'h00, 2'd2, 8'hA5, 8'hA4, 1'b1, 2'd0, 16'h0000, 8'h00}, // R12 R5 ptr=0
    '{3'd3, 8'h4A, 8'h12, 8'h34, 8'h00, 2'd1, 8'h91, 8'h00, 1'b1, 2'd0, 16'h0000, 8'h00}, // R3
    '{3'd1, 8'h1A, 8'h00, 8'h00, 8'h00, 2'd2, 8'h91, 8'h90, 1'b1, 2'd0, 16'h0000, 8'h00}, // R5
    '{3'd2, 8'h19, 8'h5C, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b1, 2'd1, 16'h1236, 8'h5C}, // R6
    '{3'd4, 8'h49, 8'h20, 8'h10, 8'h77, 2'd0, 8'h00, 8'h00, 1'b1, 2'd1, 16'h2010, 8'h77}, // R4
    '{3'd1, 8'h1A, 8'h00, 8'h00, 8'h00, 2'd2, 8'h77, 8'hB4, 1'b1, 2'd0, 16'h0000, 8'h00}, // R4 ptr
    '{3'd1, 8'h0C, 8'h00, 8'h00, 8'h00, 2'd2, 8'hBE, 8'hEF, 1'b1, 2'd0, 16'h0000, 8'h00}, // R7
    '{3'd1, 8'h28, 8'h00, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b1, 2'd2, 16'h0000, 8'h00}, // R8
    '{3'd1, 8'h55, 8'h00, 8'h00, 8'h00, 2'd0, 8'h00, 8'h00, 1'b0, 2'd0, 16'h0000, 8'h00}, // R1
    '{3'd3, 8'h4A, 8'h12, 8'h36, 8'h00, 2'd1, 8'h5C, 8'h00, 1'b1, 2'd0, 16'h0000, 8'h00}  // R6 write seen
  };

  task automatic run_vec(input vec_t v);
    logic [7:0] bs [4];
    logic [7:0] ds [2];
    bs = '{v.b0, v.b1, v.b2, v.b3};
    ds = '{v.d0, v.d1};
    for (int i = 0; i < int'(v.n); i++) begin
      send_byte(bs[i]);
      wait_tx(bs[i], D2 - 1, "R2");
    end
    for (int j = 0; j < int'(v.nd); j++) wait_tx(ds[j], D2, "R3");
    if (v.win) wait_commit(v.ck, v.wa, v.wd);
    else quiet(D11 + D2, "R1");
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    chk(1'b0, "R0", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!tx_valid && !mem_req && !run, "R12", "outputs in reset", int'({tx_valid, mem_req, run}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !mem_req && !run, "R12", "outputs after reset", int'({tx_valid, mem_req, run}), 0);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R10 break while echo pending inside write command
    w0 = wr_cnt;
    send_byte(8'h49);
    wait_tx(8'h49, D2 - 1, "R2");
    send_byte(8'h12);
    pulse_break();
    quiet(D11 + D2, "R10");
    chk(wr_cnt == w0, "R10", "write after break", wr_cnt, w0);
    // pointer still 1236
    run_vec('{3'd1, 8'h1A, 8'h00, 8'h00, 8'h00, 2'd2, 8'h5C, 8'h92, 1'b1, 2'd0, 16'h0000, 8'h00});

    // R10 break in window of indexed write
    w0 = wr_cnt;
    send_byte(8'h19);
    wait_tx(8'h19, D2 - 1, "R2");
    send_byte(8'hAA);
    wait_tx(8'hAA, D2 - 1, "R2");
    repeat (5) @(negedge clk);
    pulse_break();
    quiet(D11 + D2, "R10");
    chk(wr_cnt == w0, "R10", "window write after break", wr_cnt, w0);
    run_vec('{3'd1, 8'h1A, 8'h00, 8'h00, 8'h00, 2'd2, 8'h9D, 8'h9C, 1'b1, 2'd0, 16'h0000, 8'h00});

    // R11 byte during echo delay ignored
    send_byte(8'h1A);
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h4A;
    @(negedge clk); rx_valid = 1'b0;
    wait_tx(8'h1A, D2 - 3, "R11");
    wait_tx(8'h9F, D2, "R11");
    wait_tx(8'h9E, D2, "R11");
    wait_commit(2'd0, 16'h0000, 8'h00);

    // R4 R8 totals
    chk(wr_cnt == 2, "R4", "total writes", wr_cnt, 2);
    chk(run_cnt == 1, "R8", "total run pulses", run_cnt, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule